// File: doc/BRIEF.md
# Memory-Mapped Serial Transmitter and LED Port

This block sits on a core's data bus next to on-chip RAM and answers requests with the same timing as that RAM. A request is latched at one clock edge. Any read data is then formed combinationally from the latched request, so it is valid during the cycle after the request. Two functions live behind three fixed addresses. The first is a serial transmitter that sends one byte per write. The second is a four-bit LED output register. Software polls a ready flag before each transmit write. A transmit write that arrives while a frame is still on the line is dropped, so a frame in flight is never overwritten.

The transmitter is a four-state machine. `TX_IDLE` holds the line high and reports ready. The `accept` transition (a start pulse while idle) loads the byte and moves to `TX_START`, which drives the line low for one bit period. The `start_done` transition moves to `TX_DATA`, which shifts the eight data bits out, least significant bit first, one per bit period. The `byte_done` transition, taken after the eighth bit, moves to `TX_STOP`, which drives the line high for one bit period. The `stop_done` transition then returns to `TX_IDLE`. The bit period is `CLK_HZ/BAUD` clock cycles and is counted by a separate divider that is held cleared while idle.

Address map: transmit data at `0x1000_0000` (write, byte in bits [7:0]), status at `0x1000_0004` (read, ready in bit [0]), LED register at `0x2000_0000` (write, bits [3:0]).

Top module: `mmio_periph`

## Requirements
- R1: After reset the LED outputs are 0, the serial line is high, and a status read returns 1 (ready).
- R2: A read request latched at a clock edge yields its data during the following cycle. A status read returns the live ready flag in bit 0 with bits [31:1] zero. A read of any other address returns 0.
- R3: A write to 0x2000_0000 drives write-data bits [3:0] onto the LED outputs from the second clock edge after the request. The LEDs hold their value otherwise.
- R4: A write to 0x1000_0000 while ready starts a frame: the line goes low at the second clock edge after the request, for the start bit.
- R5: The frame sends the eight data bits least significant bit first and then a high stop bit. The line stays high while idle.
- R6: Every bit, start and stop bits included, lasts exactly CLK_HZ/BAUD clock cycles.
- R7: Ready is low from the clock edge that accepts a frame and rises exactly 10·CLK_HZ/BAUD cycles later, when the stop bit ends.
- R8: A write to 0x1000_0000 while ready is low is ignored: the current frame is unchanged and no further frame follows.
- R9: A write to the status address or to an unmapped address changes neither the LEDs, the serial line nor the ready flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Bus request present this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address of the request |
| req_wdata | input | 8 | Low byte of write data |
| rd_data | output | 32 | Read data for the request latched at the previous edge |
| uart_txd | output | 1 | Serial output line, idle high |
| led | output | 4 | LED drive |

## Verification
The hardest case to reach is a transmit write that lands while a frame is already on the line. It must be dropped without disturbing the bits being sent and without queuing a second frame. The stimulus walks the frame one negative edge at a time. It places a transmit write in the start-bit period and a status read in the middle of the data bits. It samples every bit at mid-period and at the edges of the first and last bits. It then watches the idle line for more than one frame length. Ready is probed from both sides of its rising edge by holding a status read across the last cycle of the stop bit.

// File: rtl/mmio_pkg.sv
package mmio_pkg;
    typedef enum logic [1:0] {
        TX_IDLE,
        TX_START,
        TX_DATA,
        TX_STOP
    } tx_state_e;
endpackage

// File: rtl/baud_counter.sv
module baud_counter #(
    parameter int DIV = 1085
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt;

    assign tick = (cnt == CW'(DIV - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R6: a tick is always followed by a full period without a tick
    p_tick_spacing_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/uart_tx_fsm.sv
module uart_tx_fsm
    import mmio_pkg::*;
#(
    parameter int DIV = 1085
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] data,
    output logic       txd,
    output logic       ready
);
    tx_state_e  state, state_nx;
    logic [7:0] shreg;
    logic [2:0] idx;
    logic       tick;

    baud_counter #(.DIV(DIV)) u_baud (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (state == TX_IDLE),
        .tick (tick)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= TX_IDLE;
        else        state <= state_nx;
    end

    // transitions: accept, start_done, byte_done, stop_done
    always_comb begin
        state_nx = state;
        unique case (state)
            TX_IDLE:  if (start) state_nx = TX_START;
            TX_START: if (tick)  state_nx = TX_DATA;
            TX_DATA:  if (tick && idx == 3'd7) state_nx = TX_STOP;
            TX_STOP:  if (tick)  state_nx = TX_IDLE;
            default:  state_nx = TX_IDLE;
        endcase
    end

    // shift register and bit index
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
            idx   <= '0;
        end else if (state == TX_IDLE && start) begin
            shreg <= data;
            idx   <= '0;
        end else if (state == TX_DATA && tick) begin
            shreg <= {1'b0, shreg[7:1]};
            idx   <= idx + 1'b1;
        end
    end

    // outputs
    always_comb begin
        txd   = 1'b1;
        ready = 1'b0;
        unique case (state)
            TX_IDLE:  ready = 1'b1;
            TX_START: txd   = 1'b0;
            TX_DATA:  txd   = shreg[0];
            TX_STOP:  txd   = 1'b1;
            default:  txd   = 1'b1;
        endcase
    end

    // R7: an accepted start leaves idle at the next edge
    p_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (start && ready) |=> (!ready && !txd));

    // R7: end of stop bit brings ready back
    p_stop_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TX_STOP && tick) |=> ready);

    // R6: within a bit period state and line hold
    p_hold_bit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state != TX_IDLE && !tick) |=> (state == $past(state) && txd == $past(txd)));

    // R5: idle line is high
    p_idle_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> txd);
endmodule

// File: rtl/mmio_bus.sv
module mmio_bus #(
    parameter int              ADDR_W    = 32,
    parameter int              WD_W      = 8,
    parameter int              RD_W      = 32,
    parameter int              LED_W     = 4,
    parameter logic [ADDR_W-1:0] TX_ADDR   = 32'h1000_0000,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 32'h1000_0004,
    parameter logic [ADDR_W-1:0] LED_ADDR  = 32'h2000_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [WD_W-1:0]   req_wdata,
    input  logic              tx_ready,
    output logic              tx_start,
    output logic [7:0]        tx_byte,
    output logic [LED_W-1:0]  led,
    output logic [RD_W-1:0]   rd_data
);
    logic              q_valid;
    logic              q_we;
    logic [ADDR_W-1:0] q_addr;
    logic [WD_W-1:0]   q_wdata;
    logic              wr_tx, wr_led, rd_stat;

    // request register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_valid <= 1'b0;
            q_we    <= 1'b0;
            q_addr  <= '0;
            q_wdata <= '0;
        end else begin
            q_valid <= req_valid;
            q_we    <= req_we;
            q_addr  <= req_addr;
            q_wdata <= req_wdata;
        end
    end

    assign wr_tx   = q_valid &&  q_we && (q_addr == TX_ADDR);
    assign wr_led  = q_valid &&  q_we && (q_addr == LED_ADDR);
    assign rd_stat = q_valid && !q_we && (q_addr == STAT_ADDR);

    assign tx_start = wr_tx && tx_ready;
    assign tx_byte  = q_wdata[7:0];

    always_ff @(posedge clk) begin
        if (!rst_n)      led <= '0;
        else if (wr_led) led <= q_wdata[LED_W-1:0];
    end

    always_comb begin
        rd_data = '0;
        if (rd_stat) rd_data[0] = tx_ready;
    end

    // R3: LEDs move only on a latched LED write
    p_led_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_led |=> $stable(led));

    // R2: no latched read means a zero data bus
    p_rdata_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!q_valid || q_we) |-> (rd_data == '0));
endmodule

// File: rtl/mmio_periph.sv
module mmio_periph #(
    parameter int CLK_HZ = 125_000_000,
    parameter int BAUD   = 115_200
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        req_we,
    input  logic [31:0] req_addr,
    input  logic [7:0]  req_wdata,
    output logic [31:0] rd_data,
    output logic        uart_txd,
    output logic [3:0]  led
);
    localparam int DIV = CLK_HZ / BAUD;

    logic       tx_start, tx_ready;
    logic [7:0] tx_byte;

    mmio_bus #(
        .ADDR_W(32), .WD_W(8), .RD_W(32), .LED_W(4),
        .TX_ADDR(32'h1000_0000), .STAT_ADDR(32'h1000_0004), .LED_ADDR(32'h2000_0000)
    ) u_bus (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .req_we   (req_we),
        .req_addr (req_addr),
        .req_wdata(req_wdata),
        .tx_ready (tx_ready),
        .tx_start (tx_start),
        .tx_byte  (tx_byte),
        .led      (led),
        .rd_data  (rd_data)
    );

    uart_tx_fsm #(.DIV(DIV)) u_tx (
        .clk  (clk),
        .rst_n(rst_n),
        .start(tx_start),
        .data (tx_byte),
        .txd  (uart_txd),
        .ready(tx_ready)
    );

    // R8: a start never reaches a busy transmitter
    p_no_overrun_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |-> $past(uart_txd));
endmodule

// File: tb/mmio_periph_tb.sv
`timescale 1ns/1ps
module mmio_periph_tb;
    localparam int CLK_HZ = 16;
    localparam int BAUD   = 2;
    localparam int DIV    = CLK_HZ / BAUD;
    localparam int FRAME  = 10 * DIV;
    localparam logic [31:0] A_TX   = 32'h1000_0000;
    localparam logic [31:0] A_STAT = 32'h1000_0004;
    localparam logic [31:0] A_LED  = 32'h2000_0000;

    // {write data, expected LED}
    localparam logic [11:0] LED_TAB [0:5] = '{
        {8'hA5, 4'h5}, {8'h3C, 4'hC}, {8'hFF, 4'hF},
        {8'h00, 4'h0}, {8'h96, 4'h6}, {8'h71, 4'h1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_we = 1'b0;
    logic [31:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic [31:0] rd_data;
    logic        uart_txd;
    logic [3:0]  led;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    mmio_periph #(.CLK_HZ(CLK_HZ), .BAUD(BAUD)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
        .req_addr(req_addr), .req_wdata(req_wdata), .rd_data(rd_data),
        .uart_txd(uart_txd), .led(led)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [31:0] a, input logic [7:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_we = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_we = 1'b0;
    endtask

    task automatic bus_read(input logic [31:0] a, output logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_we = 1'b0; req_addr = a;
        @(negedge clk);
        d = rd_data;
        req_valid = 1'b0;
    endtask

    task automatic send_frame(input logic [7:0] b, input bit inject);
        logic exp;
        int   bad;
        bus_write(A_TX, b);
        for (int n = 1; n <= FRAME + 1; n++) begin
            @(negedge clk);
            // samples
            if (n >= DIV/2 + 1 && n <= FRAME && ((n - 1 - DIV/2) % DIV) == 0) begin
                int bi = (n - 1) / DIV;
                exp = (bi == 0) ? 1'b0 : (bi == 9) ? 1'b1 : b[bi-1];
                if (bi == 0) chk("R4 start bit", uart_txd, 0);
                else chk("R5 frame bit", uart_txd, exp);
            end
            if (n == DIV)           chk("R6 start bit last cycle", uart_txd, 0);
            if (n == DIV + 1)       chk("R6 first data bit begins", uart_txd, b[0]);
            if (n == 9 * DIV)       chk("R6 last data bit end", uart_txd, b[7]);
            if (n == 9 * DIV + 1)   chk("R6 stop bit begins", uart_txd, 1);
            if (n == 2)             chk("R7 ready low after accept", rd_data, 0);
            if (n == 3 * DIV + 1)   chk("R2 status busy mid frame", rd_data, 0);
            if (n == FRAME)         chk("R7 ready still low in stop bit", rd_data, 0);
            if (n == FRAME + 1) begin
                chk("R7 ready rises after stop", rd_data, 1);
                chk("R5 line idle high", uart_txd, 1);
            end
            // drives
            if (n == 1 || n == 3 * DIV || n == FRAME - 1) begin
                req_valid = 1'b1; req_we = 1'b0; req_addr = A_STAT;
            end
            if (n == 2 || n == 3 * DIV + 1 || n == FRAME + 1) req_valid = 1'b0;
            if (inject && n == 3) begin
                req_valid = 1'b1; req_we = 1'b1; req_addr = A_TX; req_wdata = ~b;
            end
            if (inject && n == 4) begin
                req_valid = 1'b0; req_we = 1'b0;
            end
        end
        if (inject) begin
            bad = 0;
            for (int k = 0; k < FRAME + 2 * DIV; k++) begin
                @(negedge clk);
                if (uart_txd !== 1'b1) bad++;
            end
            chk("R8 busy write produced no frame", bad, 0);
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 100000, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] r;
        logic [3:0]  led_keep;
        int          bad;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 led reset", led, 0);
        chk("R1 txd reset", uart_txd, 1);
        bus_read(A_STAT, r);
        chk("R1 R2 status ready after reset", r, 1);

        // R3 vector table
        foreach (LED_TAB[i]) begin
            bus_write(A_LED, LED_TAB[i][11:4]);
            chk("R3 led no change before apply edge", led, (i == 0) ? 4'h0 : LED_TAB[i-1][3:0]);
            @(negedge clk);
            chk("R3 led value", led, LED_TAB[i][3:0]);
        end

        // R2 reads of non-status addresses
        bus_read(A_LED, r);
        chk("R2 read of led address", r, 0);
        bus_read(32'h3000_0000, r);
        chk("R2 read of unmapped address", r, 0);

        // R4 R5 R6 R7 frames
        send_frame(8'h35, 1'b0);
        send_frame(8'h4E, 1'b0);
        // R8 busy write
        send_frame(8'h6B, 1'b1);
        chk("R8 led untouched by frames", led, 4'h1);

        // R9 writes to status and unmapped addresses
        led_keep = led;
        bus_write(A_STAT, 8'hAB);
        bus_write(32'h3000_0000, 8'hF0);
        bus_write(32'h2000_0004, 8'hFE);
        bad = 0;
        for (int k = 0; k < 3 * DIV; k++) begin
            @(negedge clk);
            if (uart_txd !== 1'b1) bad++;
        end
        chk("R9 line idle after ignored writes", bad, 0);
        chk("R9 led unchanged", led, led_keep);
        bus_read(A_STAT, r);
        chk("R9 ready unchanged", r, 1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule